// File: doc/BRIEF.md
# Banked Stack Pointer Control Unit

This unit holds the small control register that a processor core consults in thread mode, and the two banked stack pointers: a main pointer and a process pointer. Control bit 1 picks the thread-mode stack. Control bit 0, when the privilege option is built in, makes thread-mode code unprivileged. Handler mode always runs on the main pointer. In handler mode, stack-select writes are dropped and the bit reads back as zero.

A small context state machine tracks the execution mode and the thread-mode stack selection. There are four states:
- `ST_THR_MAIN`: thread mode on the main pointer.
- `ST_THR_PROC`: thread mode on the process pointer.
- `ST_HND_MAIN`: handler mode, with main saved for thread mode.
- `ST_HND_PROC`: handler mode, with process saved for thread mode.

The transitions are:
- **Thread select write.** `ST_THR_MAIN` and `ST_THR_PROC` swap on a qualified register write whose bit 1 differs from the current selection.
- **Exception entry.** From a thread state, entry moves to the handler state that preserves the selection. Entry while already in handler mode (nesting) keeps the state.
- **Return to thread.** Return with destination thread moves from `ST_HND_x` back to `ST_THR_x`.
- **Return to handler.** Return with destination handler keeps the handler state.
- **Return in thread mode.** A return strobe while in thread mode is ignored.

Exception entry has priority over return. Either strobe has priority over a register write in the same cycle.

Top module: `sp_bank_ctrl`

## Requirements
- R1: After reset the control register reads 0, the active pointer is the main pointer (reset value 0), and the core is privileged.
- R2: Bits 31 down to 2 of the control read value are always zero, whatever is written.
- R3: A privileged thread-mode write sets bit 1, and this selects the stack: 1 gives the process pointer and 0 gives the main pointer. The active pointer output changes on the clock edge that takes the write.
- R4: In handler mode, bit 1 reads as zero and writes to bit 1 are ignored. Bit 0 remains writable.
- R5: In handler mode the active pointer is the main pointer, whatever value is held for thread mode.
- R6: With the privilege option enabled, bit 0 equal to 1 makes thread mode unprivileged (privilege output 0). Handler mode is always privileged.
- R7: With the privilege option disabled, bit 0 reads as zero and the privilege output stays 1.
- R8: Exception entry from thread mode saves the thread stack selection and switches to the main pointer. A nested entry keeps the saved value.
- R9: A return with destination thread restores the saved selection. A return with destination handler stays in handler mode on the main pointer.
- R10: Control writes made while unprivileged are ignored.
- R11: A stack pointer write updates only the active pointer, with bits 1 and 0 forced to zero.
- R12: When entry and return strobes arrive together, entry wins. A control write in the same cycle as either strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 32 | Control register write data |
| exc_entry_i | input | 1 | Exception entry strobe |
| exc_return_i | input | 1 | Exception return strobe |
| ret_to_thread_i | input | 1 | Return destination mode: 1 = thread, 0 = handler |
| sp_we_i | input | 1 | Active stack pointer write enable |
| sp_wdata_i | input | SP_W | Stack pointer write data |
| ctrl_rdata_o | output | 32 | Control register read value |
| active_sp_o | output | SP_W | Currently active stack pointer |
| privileged_o | output | 1 | 1 when current execution is privileged |

## Verification
Every cycle, the assertions check the following:
- the saved selection survives entry and comes back on return to thread;
- the selection cannot move while in handler mode;
- the pointers stay word aligned, and the inactive pointer is untouched by stack writes;
- unprivileged writes leave the register unchanged;
- handler mode drives the main pointer.

Only the bench's scenarios can show the rest. This covers strobe priority and nested entries mixed with returns to handler. It also covers the values that actually land in each banked pointer. Finally, it covers the behaviour of a build with the privilege option removed, which the bench compares against its reference model every clock.

// File: rtl/sp_ctrl_pkg.sv
package sp_ctrl_pkg;
    localparam int CTRL_W   = 32;
    localparam int SEL_BIT  = 1;
    localparam int PRIV_BIT = 0;

    typedef enum logic [1:0] {
        ST_THR_MAIN = 2'b00,
        ST_THR_PROC = 2'b01,
        ST_HND_MAIN = 2'b10,
        ST_HND_PROC = 2'b11
    } ctx_state_e;
endpackage

// File: rtl/sp_ctx_fsm.sv
module sp_ctx_fsm
    import sp_ctrl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic exc_entry_i,
    input  logic exc_return_i,
    input  logic ret_to_thread_i,
    input  logic sel_wr_i,
    input  logic sel_wdata_i,
    output logic in_handler_o,
    output logic thread_sel_o,
    output logic proc_active_o
);
    ctx_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_THR_MAIN;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_THR_MAIN: begin
                if (exc_entry_i)                      state_d = ST_HND_MAIN;
                else if (exc_return_i)                state_d = ST_THR_MAIN;
                else if (sel_wr_i && sel_wdata_i)     state_d = ST_THR_PROC;
            end
            ST_THR_PROC: begin
                if (exc_entry_i)                      state_d = ST_HND_PROC;
                else if (exc_return_i)                state_d = ST_THR_PROC;
                else if (sel_wr_i && !sel_wdata_i)    state_d = ST_THR_MAIN;
            end
            ST_HND_MAIN: begin
                if (exc_entry_i)                      state_d = ST_HND_MAIN;
                else if (exc_return_i && ret_to_thread_i) state_d = ST_THR_MAIN;
            end
            ST_HND_PROC: begin
                if (exc_entry_i)                      state_d = ST_HND_PROC;
                else if (exc_return_i && ret_to_thread_i) state_d = ST_THR_PROC;
            end
            default: state_d = ST_THR_MAIN;
        endcase
    end

    always_comb begin
        in_handler_o  = 1'b0;
        thread_sel_o  = 1'b0;
        proc_active_o = 1'b0;
        unique case (state_q)
            ST_THR_MAIN: ;
            ST_THR_PROC: begin
                thread_sel_o  = 1'b1;
                proc_active_o = 1'b1;
            end
            ST_HND_MAIN: in_handler_o = 1'b1;
            ST_HND_PROC: begin
                in_handler_o = 1'b1;
                thread_sel_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R8
    entry_saves_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_entry_i && !in_handler_o) |=> (in_handler_o && thread_sel_o == $past(thread_sel_o)));

    // R9
    return_restores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_handler_o && exc_return_i && !exc_entry_i && ret_to_thread_i)
            |=> (!in_handler_o && thread_sel_o == $past(thread_sel_o)));

    // R4
    handler_sel_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_handler_o |=> $stable(thread_sel_o));
endmodule

// File: rtl/sp_priv_reg.sv
module sp_priv_reg #(
    parameter bit ENABLE_PRIV = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_i,
    input  logic wdata_i,
    output logic unpriv_o
);
    generate
        if (ENABLE_PRIV) begin : g_priv
            logic unpriv_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)   unpriv_q <= 1'b0;
                else if (wr_i) unpriv_q <= wdata_i;
            end
            assign unpriv_o = unpriv_q;

            // R6
            priv_bit_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                wr_i |=> (unpriv_o == $past(wdata_i)));
        end else begin : g_no_priv
            assign unpriv_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sp_bank_regs.sv
module sp_bank_regs #(
    parameter int              SP_W    = 32,
    parameter logic [SP_W-1:0] MSP_RST = '0,
    parameter logic [SP_W-1:0] PSP_RST = '0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            we_i,
    input  logic [SP_W-1:0] wdata_i,
    input  logic            use_proc_i,
    output logic [SP_W-1:0] main_sp_o,
    output logic [SP_W-1:0] proc_sp_o
);
    localparam int              ALIGN_BITS = 2;
    localparam logic [SP_W-1:0] ALIGN_MASK = ~(SP_W'((1 << ALIGN_BITS) - 1));

    logic [SP_W-1:0] main_q, proc_q;
    logic [SP_W-1:0] wr_aligned;

    assign wr_aligned = wdata_i & ALIGN_MASK;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            main_q <= MSP_RST & ALIGN_MASK;
            proc_q <= PSP_RST & ALIGN_MASK;
        end else if (we_i) begin
            if (use_proc_i) proc_q <= wr_aligned;
            else            main_q <= wr_aligned;
        end
    end

    assign main_sp_o = main_q;
    assign proc_sp_o = proc_q;

    // R11
    proc_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && !use_proc_i) |=> $stable(proc_sp_o));

    // R11
    main_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && use_proc_i) |=> $stable(main_sp_o));

    // R11
    sp_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (main_sp_o[ALIGN_BITS-1:0] == '0) && (proc_sp_o[ALIGN_BITS-1:0] == '0));
endmodule

// File: rtl/sp_bank_ctrl.sv
module sp_bank_ctrl
    import sp_ctrl_pkg::*;
#(
    parameter int              SP_W        = 32,
    parameter bit              ENABLE_PRIV = 1'b1,
    parameter logic [SP_W-1:0] MSP_RST     = '0,
    parameter logic [SP_W-1:0] PSP_RST     = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              exc_entry_i,
    input  logic              exc_return_i,
    input  logic              ret_to_thread_i,
    input  logic              sp_we_i,
    input  logic [SP_W-1:0]   sp_wdata_i,
    output logic [CTRL_W-1:0] ctrl_rdata_o,
    output logic [SP_W-1:0]   active_sp_o,
    output logic              privileged_o
);
    logic in_handler, thread_sel, proc_active, unpriv;
    logic wr_ok, sel_wr;
    logic [SP_W-1:0] main_sp, proc_sp;

    assign wr_ok  = ctrl_we_i && privileged_o && !exc_entry_i && !exc_return_i;
    assign sel_wr = wr_ok && !in_handler;

    sp_ctx_fsm u_fsm (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .exc_entry_i     (exc_entry_i),
        .exc_return_i    (exc_return_i),
        .ret_to_thread_i (ret_to_thread_i),
        .sel_wr_i        (sel_wr),
        .sel_wdata_i     (ctrl_wdata_i[SEL_BIT]),
        .in_handler_o    (in_handler),
        .thread_sel_o    (thread_sel),
        .proc_active_o   (proc_active)
    );

    sp_priv_reg #(.ENABLE_PRIV(ENABLE_PRIV)) u_priv (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (wr_ok),
        .wdata_i  (ctrl_wdata_i[PRIV_BIT]),
        .unpriv_o (unpriv)
    );

    sp_bank_regs #(.SP_W(SP_W), .MSP_RST(MSP_RST), .PSP_RST(PSP_RST)) u_banks (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (sp_we_i),
        .wdata_i    (sp_wdata_i),
        .use_proc_i (proc_active),
        .main_sp_o  (main_sp),
        .proc_sp_o  (proc_sp)
    );

    always_comb begin
        ctrl_rdata_o           = '0;
        ctrl_rdata_o[SEL_BIT]  = thread_sel && !in_handler;
        ctrl_rdata_o[PRIV_BIT] = unpriv;
    end

    assign privileged_o = in_handler || !unpriv;
    assign active_sp_o  = proc_active ? proc_sp : main_sp;

    // R5
    handler_main_sp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_handler |-> (active_sp_o == main_sp));

    // R10
    unpriv_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_we_i && !privileged_o && !exc_entry_i && !exc_return_i) |=> $stable(ctrl_rdata_o));

    // R3
    sel_write_applies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_wr |=> (ctrl_rdata_o[SEL_BIT] == $past(ctrl_wdata_i[SEL_BIT])));

    // R4
    handler_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_handler |-> (ctrl_rdata_o[SEL_BIT] == 1'b0));
endmodule

// File: tb/test_sp_bank_ctrl.sv
module test_sp_bank_ctrl;
    localparam int SP_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, en = 1'b0, rt = 1'b0, rth = 1'b0, sw = 1'b0;
    logic [31:0] cd = '0;
    logic [SP_W-1:0] sd = '0;
    logic [31:0] ctrl_a, ctrl_b;
    logic [SP_W-1:0] sp_a, sp_b;
    logic priv_a, priv_b;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // reference model
    bit m_h = 0, m_sel = 0, m_saved = 0, m_np = 0;
    logic [31:0] m_msp = '0, m_psp = '0;

    always #10 clk = ~clk;

    sp_bank_ctrl #(.SP_W(SP_W), .ENABLE_PRIV(1'b1)) i_sp_bank_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ce), .ctrl_wdata_i(cd),
        .exc_entry_i(en), .exc_return_i(rt), .ret_to_thread_i(rth),
        .sp_we_i(sw), .sp_wdata_i(sd),
        .ctrl_rdata_o(ctrl_a), .active_sp_o(sp_a), .privileged_o(priv_a));

    sp_bank_ctrl #(.SP_W(SP_W), .ENABLE_PRIV(1'b0)) i_sp_bank_ctrl_nopriv (
        .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ce), .ctrl_wdata_i(cd),
        .exc_entry_i(en), .exc_return_i(rt), .ret_to_thread_i(rth),
        .sp_we_i(sw), .sp_wdata_i(sd),
        .ctrl_rdata_o(ctrl_b), .active_sp_o(sp_b), .privileged_o(priv_b));

    task automatic chk32(string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] exp_ctrl;
        exp_ctrl = {30'b0, (m_h ? 1'b0 : m_sel), m_np};
        chk32("ctrl", ctrl_a, exp_ctrl);
        chk32("active_sp", sp_a, (m_h || !m_sel) ? m_msp : m_psp);
        chk32("privileged", {31'b0, priv_a}, {31'b0, (m_h || !m_np)});
        // R7: build without the privilege option
        chk32("R7 nopriv bit0", {31'b0, ctrl_b[0]}, 32'h0);
        chk32("R7 nopriv privileged", {31'b0, priv_b}, 32'h1);
        chk32("R2 upper bits", {2'b0, ctrl_a[31:2]}, 32'h0);
    endtask

    task automatic model_step();
        bit pv;
        pv = m_h || !m_np;
        if (sw) begin
            if (!m_h && m_sel) m_psp = sd & 32'hFFFF_FFFC;
            else               m_msp = sd & 32'hFFFF_FFFC;
        end
        if (en) begin
            if (!m_h) begin m_saved = m_sel; m_h = 1; end
        end else if (rt) begin
            if (m_h && rth) begin m_h = 0; m_sel = m_saved; end
        end else if (ce && pv) begin
            m_np = cd[0];
            if (!m_h) m_sel = cd[1];
        end
    endtask

    task automatic cyc(string t, bit c_we, logic [31:0] c_d, bit e, bit r, bit r_th,
                       bit s_we, logic [31:0] s_d);
        tag = t;
        ce = c_we; cd = c_d; en = e; rt = r; rth = r_th; sw = s_we; sd = s_d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        ce = 0; en = 0; rt = 0; sw = 0;
        compare();
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit [31:0] lfsr;
        repeat (3) @(negedge clk);
        tag = "R1";
        compare();
        rst_n = 1'b1;
        @(negedge clk);
        compare();
        cyc("R11", 0, 0, 0, 0, 0, 1, 32'h0000_1003);       // main <= 0x1000
        cyc("R3",  1, 32'h2, 0, 0, 0, 0, 0);               // select process
        cyc("R11", 0, 0, 0, 0, 0, 1, 32'h0000_2005);       // process <= 0x2004
        cyc("R2",  1, 32'hFFFF_FFFE, 0, 0, 0, 0, 0);
        cyc("R8",  0, 0, 1, 0, 0, 0, 0);                   // entry
        cyc("R5",  0, 0, 0, 0, 0, 1, 32'h0000_3001);       // handler writes main
        cyc("R4",  1, 32'h0, 0, 0, 0, 0, 0);
        cyc("R8",  0, 0, 1, 0, 0, 0, 0);                   // nested entry
        cyc("R9",  0, 0, 0, 1, 0, 0, 0);                   // return to handler
        cyc("R6",  1, 32'h3, 0, 0, 0, 0, 0);               // bit0 set, bit1 ignored
        cyc("R9",  0, 0, 0, 1, 1, 0, 0);                   // back to thread
        cyc("R6",  0, 0, 0, 0, 0, 0, 0);
        cyc("R10", 1, 32'h0, 0, 0, 0, 0, 0);               // unprivileged write
        cyc("R12", 0, 0, 1, 1, 1, 0, 0);                   // entry wins
        cyc("R12", 1, 32'h0, 0, 0, 0, 0, 0);               // clear bit0 in handler
        cyc("R9",  0, 0, 0, 1, 1, 0, 0);
        cyc("R12", 1, 32'h0, 1, 0, 0, 0, 0);               // write dropped with entry
        cyc("R12", 1, 32'h1, 0, 1, 1, 0, 0);               // write dropped with return
        cyc("R3",  1, 32'h0, 0, 0, 0, 0, 0);
        cyc("R3",  1, 32'h2, 0, 0, 0, 0, 0);
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc("R8", lfsr[0] & lfsr[3], {30'b0, lfsr[5:4]},
                lfsr[6] & lfsr[7] & lfsr[8], lfsr[9] & lfsr[10], lfsr[11],
                lfsr[12], lfsr);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule